// File: doc/BRIEF.md
# Configurable Serial Word Receiver

This block turns a synchronous serial bit stream into a 16-bit parallel word for a downstream receive FIFO. The serial bit clock arrives as a level on an input and is sampled in the system clock domain. A bit is captured in the system cycle in which a rising bit-clock edge is seen. A mode input chooses continuous-clock operation, where a frame sync qualifies every edge, or gated-clock operation, where every rising edge carries data and the frame sync is ignored.

Three settings control how a word is built: a 2-bit word-length code, a direction bit and an alignment bit. Together they decide which of the 16 result bits each incoming bit lands in. Positions that the word does not cover read as zero. The settings are taken when the first bit of a word is captured and are held for the rest of that word. When the final bit arrives, the block presents the completed word and raises a one-cycle valid strobe.

Top module: `srx_deser`

## Requirements
- R1: While rst_ni is low, and directly after it is released, word_o is 0 and valid_o is 0. The first captured bit after reset is bit 0 of a new word.
- R2: Word-length code wl_i = 2'b00 captures 8 bits per word, 2'b01 captures 10, 2'b10 captures 12 and 2'b11 captures 16. valid_o stays low until the last of those bits is captured.
- R3: With align_i=0 and dir_i=0, received bit k (k=0 first) lands at position 15-k.
- R4: With align_i=0 and dir_i=1, received bit k lands at position 16-n+k, where n is the word length.
- R5: With align_i=1 and dir_i=0, received bit k lands at position k.
- R6: With align_i=1 and dir_i=1, received bit k lands at position n-1-k.
- R7: Every position of word_o that the word does not cover is 0 when valid_o is high.
- R8: With gated_i=0, a rising bit-clock edge captures sdata_i only when fsync_i is high. Edges seen while fsync_i is low do not advance the word.
- R9: With gated_i=1, every rising bit-clock edge captures sdata_i, whatever the level of fsync_i.
- R10: valid_o is high for exactly the one cycle that follows the cycle in which the last bit is captured. word_o changes only in that cycle and then holds until the next word completes.
- R11: wl_i, dir_i and align_i are taken in the cycle of a word's first capture. Changes made later in the word do not affect that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data |
| bclk_i | input | 1 | Bit clock level, rising edge captures |
| fsync_i | input | 1 | Frame sync, qualifies edges in continuous mode |
| gated_i | input | 1 | 1 = gated-clock mode, 0 = continuous-clock mode |
| wl_i | input | 2 | Word-length code |
| dir_i | input | 1 | Shift direction select |
| align_i | input | 1 | Bit-0 alignment select |
| word_o | output | 16 | Assembled word |
| valid_o | output | 1 | One-cycle strobe, new word on word_o |

## Verification
Two things can happen in the same cycle: the first capture of a word and a change to the configuration inputs. In the sweep, the bench sets a new length, direction and alignment in the same cycle that the first bit is driven, and expects the word to follow the new settings. A separate test then changes all three settings just after the first bit of a word. It expects the completed word to follow the settings that were taken at the start of that word.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic [1:0] wl;
    logic       dir;
    logic       align;
  } srx_cfg_t;

  function automatic int unsigned word_len(input logic [1:0] wl, input int unsigned w);
    return (wl == 2'b11) ? w : 32'd8 + 32'd2 * {30'd0, wl};
  endfunction

  // target position of the k-th received bit
  function automatic int unsigned bit_pos(input srx_cfg_t c, input int unsigned n,
                                          input int unsigned k, input int unsigned w);
    case ({c.align, c.dir})
      2'b00:   return w - 1 - k;
      2'b01:   return w - n + k;
      2'b10:   return k;
      default: return n - 1 - k;
    endcase
  endfunction
endpackage

// File: rtl/srx_bclk_qual.sv
module srx_bclk_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic gated_i,
  output logic cap_o
);
  logic bclk_q;

  // reset high: a level already high after reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) bclk_q <= 1'b1;
    else         bclk_q <= bclk_i;

  assign cap_o = bclk_i & ~bclk_q & (gated_i | fsync_i);
endmodule

// File: rtl/srx_seq.sv
module srx_seq
  import srx_pkg::*;
#(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W),
  localparam int unsigned PW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  srx_cfg_t      cfg_i,
  output logic          first_o,
  output logic          last_o,
  output logic [PW-1:0] pos_o,
  output logic [CW-1:0] cnt_o,
  output srx_cfg_t      cfg_q_o
);
  logic [CW-1:0] cnt_q;
  srx_cfg_t      cfg_q, cfg_eff;
  int unsigned   len;

  assign first_o = (cnt_q == '0);
  assign cfg_eff = first_o ? cfg_i : cfg_q;
  assign len     = word_len(cfg_eff.wl, W);
  assign last_o  = (32'(cnt_q) == len - 1);
  assign pos_o   = PW'(bit_pos(cfg_eff, len, 32'(cnt_q), W));
  assign cnt_o   = cnt_q;
  assign cfg_q_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else if (cap_i) begin
      if (first_o) cfg_q <= cfg_i;
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/srx_assemble.sv
module srx_assemble #(
  parameter int unsigned W  = 16,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic [PW-1:0] pos_i,
  input  logic          sdata_i,
  output logic [W-1:0]  word_o,
  output logic          valid_o
);
  logic [W-1:0] hold_q, hold_nxt;

  // a new word starts from all zeros, which gives the padding
  always_comb begin
    hold_nxt        = first_i ? '0 : hold_q;
    hold_nxt[pos_i] = sdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_q  <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i & last_i;
      if (cap_i) begin
        hold_q <= hold_nxt;
        if (last_i) word_o <= hold_nxt;
      end
    end
endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W),
  localparam int unsigned PW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sdata_i,
  input  logic         bclk_i,
  input  logic         fsync_i,
  input  logic         gated_i,
  input  logic [1:0]   wl_i,
  input  logic         dir_i,
  input  logic         align_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  logic          cap, first, last;
  logic [PW-1:0] pos;
  logic [CW-1:0] cnt_q;
  srx_cfg_t      cfg_live, cfg_q;

  assign cfg_live = '{wl: wl_i, dir: dir_i, align: align_i};

  srx_bclk_qual u_qual (
    .clk_i, .rst_ni, .bclk_i, .fsync_i, .gated_i, .cap_o(cap)
  );

  srx_seq #(.W(W)) u_seq (
    .clk_i, .rst_ni, .cap_i(cap), .cfg_i(cfg_live),
    .first_o(first), .last_o(last), .pos_o(pos), .cnt_o(cnt_q), .cfg_q_o(cfg_q)
  );

  srx_assemble #(.W(W)) u_asm (
    .clk_i, .rst_ni, .cap_i(cap), .first_i(first), .last_i(last),
    .pos_i(pos), .sdata_i, .word_o, .valid_o
  );
endmodule

// File: rtl/srx_deser_chk.sv
module srx_deser_chk
  import srx_pkg::*;
#(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fsync_i,
  input logic          gated_i,
  input logic          valid_o,
  input logic [W-1:0]  word_o,
  input logic [CW-1:0] cnt_q,
  input srx_cfg_t      cfg_q
);
  function automatic logic [W-1:0] used_mask(input srx_cfg_t c);
    int unsigned n;
    logic [W-1:0] m;
    n = word_len(c.wl, W);
    for (int unsigned i = 0; i < W; i++)
      m[i] = c.align ? (i < n) : (i >= W - n);
    return m;
  endfunction

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r10_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  a_r7_zero_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((word_o & ~used_mask(cfg_q)) == '0));

  a_r8_no_sync_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gated_i && !fsync_i) |=> $stable(cnt_q));

  a_r11_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(cfg_q));

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (32'(cnt_q) < word_len(cfg_q.wl, W)));
endmodule

bind srx_deser srx_deser_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i), .gated_i(gated_i),
  .valid_o(valid_o), .word_o(word_o), .cnt_q(cnt_q), .cfg_q(cfg_q)
);

// File: tb/sim_srx_deser.sv
module sim_srx_deser;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sdata = 1'b0, bclk = 1'b0, fsync = 1'b0, gated = 1'b0;
  logic [1:0]  wl = 2'b00;
  logic        dir = 1'b0, align = 1'b0;
  logic [15:0] word;
  logic        valid;
  int          errs = 0, checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  srx_deser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .bclk_i(bclk), .fsync_i(fsync),
    .gated_i(gated), .wl_i(wl), .dir_i(dir), .align_i(align),
    .word_o(word), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] c);
    return (c == 2'b11) ? 16 : 8 + 2 * int'(c);
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] d, input int n, input logic a, input logic dr);
    int f, s;
    logic [15:0] e = '0;
    f = a ? (dr ? n - 1 : 0) : (dr ? 16 - n : 15);
    s = (a ^ dr) ? 1 : -1;
    for (int k = 0; k < n; k++) e[f + s * k] = d[k];
    return e;
  endfunction

  function automatic logic [15:0] pad_mask(input int n, input logic a);
    logic [15:0] m = '0;
    for (int i = 0; i < 16; i++) m[i] = a ? (i < n) : (i >= 16 - n);
    return m;
  endfunction

  // called at a negedge; returns at the negedge after the capture edge
  task automatic send_bit(input logic b, input logic fs);
    bclk = 1'b0; sdata = b; fsync = fs;
    @(negedge clk);
    bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int c);
    bclk = 1'b0; fsync = 1'b0;
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  string rq;

  initial begin
    logic [15:0] d, e, prev;
    int n;
    idle(3);
    chk(word == 16'h0 && valid == 1'b0, "R1 reset state", {word[15:1], valid}, 16'h0);
    rst_ni = 1'b1;
    idle(2);
    chk(word == 16'h0 && valid == 1'b0, "R1 after release", word, 16'h0);

    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 16; c++) begin
        for (int p = 0; p < 3; p++) begin
          gated = m[0];
          wl = c[1:0]; dir = c[2]; align = c[3];
          n = len_of(wl);
          d = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h3A5C ^ 16'(c) : 16'($urandom);
          e = exp_word(d, n, align, dir);
          case ({align, dir})
            2'b00: rq = "R3"; 2'b01: rq = "R4"; 2'b10: rq = "R5"; default: rq = "R6";
          endcase
          for (int k = 0; k < n; k++) begin
            if (m == 0 && p == 2) send_bit(~d[k], 1'b0); // R8 unqualified edge
            send_bit(d[k], (m == 1) ? 1'($urandom) : 1'b1); // R9 random sync in gated mode
            if (k < n - 1) chk(valid == 1'b0, "R2 no early valid", {15'd0, valid}, 16'd0);
          end
          chk(valid == 1'b1, "R2 valid after last bit", {15'd0, valid}, 16'd1);
          chk(word == e, (m == 1) ? {rq, " R9 gated"} : ((p == 2) ? {rq, " R8 gaps"} : rq), word, e);
          chk((word & ~pad_mask(n, align)) == 16'h0, "R7 padding", word & ~pad_mask(n, align), 16'h0);
          prev = word;
          idle(1);
          chk(valid == 1'b0 && word == prev, "R10 one-cycle pulse, word held", {15'd0, valid}, 16'd0);
        end
      end
    end

    // R8: a whole frame of edges with sync low captures nothing
    gated = 1'b0; wl = 2'b00; dir = 1'b0; align = 1'b0;
    prev = word;
    for (int k = 0; k < 16; k++) begin
      send_bit(1'b1, 1'b0);
      chk(valid == 1'b0 && word == prev, "R8 edges without sync ignored", word, prev);
    end
    d = 16'h0096;
    for (int k = 0; k < 8; k++) send_bit(d[k], 1'b1);
    e = exp_word(d, 8, 1'b0, 1'b0);
    chk(valid == 1'b1 && word == e, "R8 word after ignored edges", word, e);
    idle(1);

    // R11: settings changed after the first bit do not affect the word
    wl = 2'b00; dir = 1'b0; align = 1'b0;
    d = 16'h00B1;
    send_bit(d[0], 1'b1);
    wl = 2'b11; dir = 1'b1; align = 1'b1;
    for (int k = 1; k < 8; k++) send_bit(d[k], 1'b1);
    e = exp_word(d, 8, 1'b0, 1'b0);
    chk(valid == 1'b1, "R11 length held", {15'd0, valid}, 16'd1);
    chk(word == e, "R11 placement held", word, e);
    idle(1);
    // next word takes the new settings
    d = 16'hC3E1;
    for (int k = 0; k < 16; k++) send_bit(d[k], 1'b1);
    e = exp_word(d, 16, 1'b1, 1'b1);
    chk(valid == 1'b1 && word == e, "R11 new settings on next word", word, e);
    idle(2);

    // R1: reset mid-word restarts the count
    wl = 2'b00; dir = 1'b0; align = 1'b1;
    for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b1);
    rst_ni = 1'b0;
    idle(1);
    chk(word == 16'h0 && valid == 1'b0, "R1 reset clears word", word, 16'h0);
    rst_ni = 1'b1;
    idle(1);
    d = 16'h005A;
    for (int k = 0; k < 8; k++) send_bit(d[k], 1'b1);
    e = exp_word(d, 8, 1'b1, 1'b0);
    chk(valid == 1'b1 && word == e, "R1 count restarts after reset", word, e);
    idle(2);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule